// File: doc/BRIEF.md
# Power-Rail Fault Supervisor

This block sits between the digitized fault comparators of a multi-rail power manager and the regulator enable lines. It owns the main regulator enable bit, derives the LED driver enable and the LED converter enable from it, and raises a fast-shutdown request for the bias, offset and reset rails. Each fault class gets its own reaction. A main-regulator fault latches the system off. Loss of the auxiliary rail's power-good pauses the LED converter and lets it retry on its own. An LED overvoltage only raises a flag. A logic-rail undervoltage triggers an immediate fast shutdown that only a power-pin cycle undoes.

The projector power pin is brought in through a two-flop synchronizer. A rising edge on it powers the system up and clears every latched-off condition. A low level on it holds the system off. The supply-undervoltage flag is accepted only after a fixed 200 µs of stability. The low-battery flag uses a host-selected stability time of 0 to 100 µs. Both times are counted in system clocks derived from a clock-frequency parameter. Each accepted fault condition raises a one-cycle event pulse for the interrupt register.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: When either main-regulator fault input (loss of regulation or no inductor current rise) is high at a clock edge, `main_en_o` and `led_drv_en_o` are low after that edge and `evt_o[0]` pulses on the first such cycle.
- R2: `led_drv_en_o` is never high while `main_en_o` is low; it turns on one cycle after `main_en_o` turns on and turns off in the same cycle as `main_en_o`.
- R3: After a main-regulator fault while `main_flt_mask_i` is low, `host_en_set_i` cannot turn `main_en_o` back on; only a low-then-high cycle of `proj_on_i` restores it.
- R4: After a main-regulator fault while `main_flt_mask_i` is high, a pulse on `host_en_set_i` (with the fault gone and the pin high) turns `main_en_o` back on.
- R5: While `aux_pg_fail_i` is high, `led_conv_en_o` is low and `evt_o[1]` pulses on its rise; once the input clears, `led_conv_en_o` returns by itself after RETRY_US microseconds of clocks.
- R6: `led_ovp_i` pulses `evt_o[2]` on its rise and leaves all enables unchanged.
- R7: `logic_uv_i` high sets `fast_shdn_o` and clears `main_en_o` on the next edge and pulses `evt_o[3]`; both stay that way until `proj_on_i` goes low and then high.
- R8: `sup_uv_i` is accepted only after it has been stable for 200 µs of clocks; a shorter glitch has no effect. Once accepted, it pulses `evt_o[4]` and holds the system off until a `proj_on_i` cycle.
- R9: `bat_low_i` is accepted after `bat_dly_us_i` microseconds of stability, with values above 100 treated as 100. Once accepted it only pulses `evt_o[5]`.
- R10: `proj_on_i` passes through two synchronizer flops. Its rising edge sets `main_en_o` on the third clock edge after the change, and a low pin clears `main_en_o`.
- R11: While `rst_ni` is low, and for the two synchronizing cycles after its release, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| proj_on_i | input | 1 | Projector power pin, asynchronous |
| host_en_set_i | input | 1 | Host write setting the main enable bit (one-cycle pulse) |
| main_flt_mask_i | input | 1 | Host mask of the main-regulator fault interrupt |
| main_oor_i | input | 1 | Main regulator output out of regulation |
| main_ind_i | input | 1 | Main regulator inductor current did not rise |
| aux_pg_fail_i | input | 1 | Auxiliary rail below power-good |
| led_ovp_i | input | 1 | LED converter output overvoltage |
| logic_uv_i | input | 1 | Logic rail undervoltage |
| sup_uv_i | input | 1 | Raw supply undervoltage comparator flag |
| bat_low_i | input | 1 | Raw low-battery comparator flag |
| bat_dly_us_i | input | 7 | Low-battery stability time in microseconds |
| main_en_o | output | 1 | Main regulator enable |
| led_drv_en_o | output | 1 | LED driver enable |
| led_conv_en_o | output | 1 | LED converter enable |
| fast_shdn_o | output | 1 | Fast shutdown request for bias, offset and reset rails |
| evt_o | output | 6 | Event pulses: 0 main fault, 1 aux power-good, 2 overvoltage, 3 logic UV, 4 supply UV, 5 low battery |

## Verification
Main-regulator faults are applied with the mask low and with the mask high, followed by host writes and by pin cycles. This tells the latched recovery apart from the host-restartable one. Power-good loss and overvoltage are applied while the LED path is running, which separates auto-retry from flag-only handling. Undervoltage and low-battery flags are given as glitches shorter than the stability time and as holds longer than it, with the low-battery time both at zero and above its clamp. This shows the window length and the clamp. A behavioural model follows every output on every clock, so a wrong latency in the synchronizer, the deglitch counters or the retry timer shows up as a mismatch in the cycle where it occurs.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int EV_MAIN = 0;
  localparam int EV_AUXPG = 1;
  localparam int EV_OVP = 2;
  localparam int EV_LOGUV = 3;
  localparam int EV_SUPUV = 4;
  localparam int EV_BATLO = 5;
  localparam int EV_N = 6;

  localparam int SUPUV_US = 200;
  localparam int BATLO_MAX_US = 100;

  function automatic int cyc_per_us(input int hz);
    return (hz / 1_000_000 < 1) ? 1 : hz / 1_000_000;
  endfunction
endpackage

// File: rtl/pfs_rst_sync.sv
module pfs_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic stg1_q, stg2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= 1'b1;
      stg2_q <= stg1_q;
    end
  end

  assign rst_sync_no = stg2_q;
endmodule

// File: rtl/pfs_sync2.sv
module pfs_sync2 #(
  parameter int WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pfs_deglitch.sv
module pfs_deglitch #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          raw_i,
  input  logic [CW-1:0] lim_i,
  output logic          lvl_o
);
  logic          lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (raw_i == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q >= lim_i) begin
      lvl_d = raw_i;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign lvl_o = lvl_q;

  // R8
  lvl_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> ($past(cnt_q) >= $past(lim_i)));
endmodule

// File: rtl/pfs_retry.sv
module pfs_retry #(
  parameter int RW = 8,
  parameter int RELOAD = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  output logic ready_o
);
  logic [RW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = fail_i || (cnt_q != '0);
    if (fail_i) cnt_d = RW'(RELOAD);
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready_o = !fail_i && (cnt_en ? (cnt_d == '0) : 1'b1);

  // R5
  retry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |=> (cnt_q == RW'(RELOAD)));
endmodule

// File: rtl/pwr_fault_supervisor.sv
module pwr_fault_supervisor
  import pfs_pkg::*;
#(
  parameter int CLK_HZ = 250_000_000,
  parameter int RETRY_US = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            proj_on_i,
  input  logic            host_en_set_i,
  input  logic            main_flt_mask_i,
  input  logic            main_oor_i,
  input  logic            main_ind_i,
  input  logic            aux_pg_fail_i,
  input  logic            led_ovp_i,
  input  logic            logic_uv_i,
  input  logic            sup_uv_i,
  input  logic            bat_low_i,
  input  logic [6:0]      bat_dly_us_i,
  output logic            main_en_o,
  output logic            led_drv_en_o,
  output logic            led_conv_en_o,
  output logic            fast_shdn_o,
  output logic [EV_N-1:0] evt_o
);
  localparam int CPU = cyc_per_us(CLK_HZ);
  localparam int SUPUV_CYC = SUPUV_US * CPU;
  localparam int DW = $clog2(SUPUV_CYC + 1);
  localparam int RETRY_CYC = RETRY_US * CPU;
  localparam int RW = $clog2(RETRY_CYC + 2);

  logic rst_n;
  logic pin_s, pin_q, pin_rise;
  logic main_flt, sup_uv_lvl, bat_low_lvl, conv_ready;
  logic [6:0] bat_us;
  logic [DW-1:0] bat_lim;

  logic lock_main_q, lock_main_d;
  logic lock_fs_q, lock_fs_d;
  logic lock_uv_q, lock_uv_d;
  logic men_q, men_d, led_q, led_d, conv_q, conv_d;
  logic blocked;
  logic [EV_N-1:0] cond, cond_q, evt_q, evt_d;

  pfs_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n));

  pfs_sync2 #(.WIDTH(1)) u_pin (.clk_i(clk_i), .rst_ni(rst_n), .d_i(proj_on_i), .q_o(pin_s));

  assign bat_us  = (bat_dly_us_i > 7'(BATLO_MAX_US)) ? 7'(BATLO_MAX_US) : bat_dly_us_i;
  assign bat_lim = DW'(bat_us) * DW'(CPU);

  pfs_deglitch #(.CW(DW)) u_dg_sup (
    .clk_i(clk_i), .rst_ni(rst_n), .raw_i(sup_uv_i),
    .lim_i(DW'(SUPUV_CYC)), .lvl_o(sup_uv_lvl));

  pfs_deglitch #(.CW(DW)) u_dg_bat (
    .clk_i(clk_i), .rst_ni(rst_n), .raw_i(bat_low_i),
    .lim_i(bat_lim), .lvl_o(bat_low_lvl));

  pfs_retry #(.RW(RW), .RELOAD(RETRY_CYC)) u_retry (
    .clk_i(clk_i), .rst_ni(rst_n), .fail_i(aux_pg_fail_i), .ready_o(conv_ready));

  assign main_flt = main_oor_i | main_ind_i;
  assign pin_rise = pin_s & ~pin_q;

  always_comb begin
    lock_main_d = lock_main_q;
    if (main_flt && !main_flt_mask_i) lock_main_d = 1'b1;
    else if (pin_rise)                lock_main_d = 1'b0;

    lock_fs_d = lock_fs_q;
    if (logic_uv_i)    lock_fs_d = 1'b1;
    else if (pin_rise) lock_fs_d = 1'b0;

    lock_uv_d = lock_uv_q;
    if (sup_uv_lvl)    lock_uv_d = 1'b1;
    else if (pin_rise) lock_uv_d = 1'b0;

    blocked = lock_main_d | lock_fs_d | lock_uv_d;

    men_d = men_q;
    if (main_flt || logic_uv_i || sup_uv_lvl || !pin_s) men_d = 1'b0;
    else if ((pin_rise || host_en_set_i) && !blocked)    men_d = 1'b1;

    led_d  = men_d & men_q;
    conv_d = led_d & conv_ready;
  end

  always_comb begin
    cond = '0;
    cond[EV_MAIN]  = main_flt;
    cond[EV_AUXPG] = aux_pg_fail_i;
    cond[EV_OVP]   = led_ovp_i;
    cond[EV_LOGUV] = logic_uv_i;
    cond[EV_SUPUV] = sup_uv_lvl;
    cond[EV_BATLO] = bat_low_lvl;
  end

  for (genvar g = 0; g < EV_N; g++) begin : g_evt
    assign evt_d[g] = cond[g] & ~cond_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      pin_q       <= 1'b0;
      lock_main_q <= 1'b0;
      lock_fs_q   <= 1'b0;
      lock_uv_q   <= 1'b0;
      men_q       <= 1'b0;
      led_q       <= 1'b0;
      conv_q      <= 1'b0;
      cond_q      <= '0;
      evt_q       <= '0;
    end else begin
      pin_q       <= pin_s;
      lock_main_q <= lock_main_d;
      lock_fs_q   <= lock_fs_d;
      lock_uv_q   <= lock_uv_d;
      men_q       <= men_d;
      led_q       <= led_d;
      conv_q      <= conv_d;
      cond_q      <= cond;
      evt_q       <= evt_d;
    end
  end

  assign main_en_o     = men_q;
  assign led_drv_en_o  = led_q;
  assign led_conv_en_o = conv_q;
  assign fast_shdn_o   = lock_fs_q;
  assign evt_o         = evt_q;

  // R1
  main_off_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (main_oor_i || main_ind_i) |=> (!main_en_o && !led_drv_en_o));
  // R2
  led_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !main_en_o |-> !led_drv_en_o);
  // R2
  led_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(led_drv_en_o) |-> $past(main_en_o));
  // R3
  latched_off_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lock_main_q && !pin_rise) |=> !main_en_o);
  // R5
  aux_pg_off_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    aux_pg_fail_i |=> !led_conv_en_o);
  // R5
  conv_needs_drv_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    led_conv_en_o |-> led_drv_en_o);
  // R7
  fast_shdn_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    logic_uv_i |=> (fast_shdn_o && !main_en_o));
  // R10
  pin_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !pin_s |=> !main_en_o);
endmodule

// File: tb/pwr_fault_supervisor_bench.sv
module pwr_fault_supervisor_bench;
  localparam int CLK_HZ = 10_000_000;
  localparam int CPU = 10;
  localparam int RETRY_US = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic proj_on = 0, host_set = 0, mask = 0, oor = 0, ind = 0;
  logic pgf = 0, ovp = 0, luv = 0, suv = 0, blo = 0;
  logic [6:0] bdly = 7'd0;
  logic men, led, conv, fsd;
  logic [5:0] evt;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [5:0] seen = '0;

  always #2 clk = ~clk;

  pwr_fault_supervisor #(.CLK_HZ(CLK_HZ), .RETRY_US(RETRY_US)) u_pwr_fault_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .proj_on_i(proj_on), .host_en_set_i(host_set),
    .main_flt_mask_i(mask), .main_oor_i(oor), .main_ind_i(ind), .aux_pg_fail_i(pgf),
    .led_ovp_i(ovp), .logic_uv_i(luv), .sup_uv_i(suv), .bat_low_i(blo),
    .bat_dly_us_i(bdly), .main_en_o(men), .led_drv_en_o(led), .led_conv_en_o(conv),
    .fast_shdn_o(fsd), .evt_o(evt));

  // behavioural reference model
  bit r1, r2, p1, p2, p3, lk_m, lk_f, lk_u, m_en, m_led, m_conv;
  bit uvl, bll;
  int uvc, blc, rc;
  bit [5:0] prev, m_evt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1 = 0; r2 = 0; p1 = 0; p2 = 0; p3 = 0; lk_m = 0; lk_f = 0; lk_u = 0;
      m_en = 0; m_led = 0; m_conv = 0; uvl = 0; bll = 0; uvc = 0; blc = 0; rc = 0;
      prev = 0; m_evt = 0;
    end else if (!r2) begin
      r2 = r1; r1 = 1;
    end else begin
      bit flt, rise, blk, n_en, n_uvl, n_bll;
      bit [5:0] c;
      int blim, n_uvc, n_blc;
      flt = oor | ind;
      rise = p2 && !p3;
      if (flt && !mask) lk_m = 1; else if (rise) lk_m = 0;
      if (luv) lk_f = 1; else if (rise) lk_f = 0;
      if (uvl) lk_u = 1; else if (rise) lk_u = 0;
      blk = lk_m | lk_f | lk_u;
      n_en = m_en;
      if (flt || luv || uvl || !p2) n_en = 0;
      else if ((rise || host_set) && !blk) n_en = 1;
      m_led = n_en && m_en;
      m_en = n_en;
      if (pgf) rc = RETRY_US * CPU; else if (rc > 0) rc = rc - 1;
      m_conv = m_led && !pgf && rc == 0;
      c = {bll, uvl, luv, ovp, pgf, flt};
      m_evt = c & ~prev;
      prev = c;
      n_uvl = uvl; n_uvc = uvc;
      if (suv == uvl) n_uvc = 0;
      else if (uvc >= 200 * CPU) begin n_uvl = suv; n_uvc = 0; end
      else n_uvc = uvc + 1;
      blim = ((bdly > 100) ? 100 : int'(bdly)) * CPU;
      n_bll = bll; n_blc = blc;
      if (blo == bll) n_blc = 0;
      else if (blc >= blim) begin n_bll = blo; n_blc = 0; end
      else n_blc = blc + 1;
      uvl = n_uvl; uvc = n_uvc; bll = n_bll; blc = n_blc;
      p3 = p2; p2 = p1; p1 = proj_on;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  string evt_tag[6] = '{"R1", "R5", "R6", "R7", "R8", "R9"};

  always @(negedge clk) begin
    if (!done) begin
      seen |= evt;
      chk(men, m_en, "R1 main_en vs model");
      chk(led, m_led, "R2 led_drv vs model");
      chk(conv, m_conv, "R5 led_conv vs model");
      chk(fsd, lk_f, "R7 fast_shdn vs model");
      for (int i = 0; i < 6; i++) chk(evt[i], m_evt[i], evt_tag[i]);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_cycle();
    proj_on = 0; tick(5);
    proj_on = 1; tick(5);
  endtask

  task automatic host_pulse();
    host_set = 1; tick(1); host_set = 0; tick(2);
  endtask

  initial begin
    tick(3);
    chk(men | led | conv | fsd | |evt, 1'b0, "R11 outputs low in reset");
    rst_n = 1;
    tick(1);
    chk(men | led | conv | fsd, 1'b0, "R11 outputs low during reset sync");
    tick(3);
    // R10 power-up through synchronizer
    proj_on = 1; tick(2);
    chk(men, 1'b0, "R10 not yet through synchronizer");
    tick(1);
    chk(men, 1'b1, "R10 enable on third edge");
    tick(3);
    chk(led, 1'b1, "R2 led driver on");
    chk(conv, 1'b1, "R5 converter on");
    // R6 overvoltage flag only
    seen = 0; ovp = 1; tick(3); ovp = 0; tick(2);
    chk(conv, 1'b1, "R6 converter kept on");
    chk(seen[2], 1'b1, "R6 event seen");
    // R5 auto retry
    seen = 0; pgf = 1; tick(5);
    chk(conv, 1'b0, "R5 converter off");
    chk(men, 1'b1, "R5 main untouched");
    pgf = 0; tick(25);
    chk(conv, 1'b1, "R5 converter retried");
    chk(seen[1], 1'b1, "R5 event seen");
    // R1 / R3 unmasked fault latches
    seen = 0; oor = 1; tick(1); oor = 0; tick(2);
    chk(men, 1'b0, "R1 main off after fault");
    chk(led, 1'b0, "R2 led off with main");
    chk(seen[0], 1'b1, "R1 event seen");
    host_pulse();
    chk(men, 1'b0, "R3 host write ignored");
    pin_cycle();
    chk(men, 1'b1, "R3 pin cycle restores");
    // R4 masked fault, host restart
    mask = 1; ind = 1; tick(2); ind = 0; tick(2);
    chk(men, 1'b0, "R4 main off after masked fault");
    host_pulse();
    chk(men, 1'b1, "R4 host write restores");
    mask = 0; tick(3);
    // R7 logic rail undervoltage
    seen = 0; luv = 1; tick(1); luv = 0; tick(3);
    chk(fsd, 1'b1, "R7 fast shutdown held");
    chk(men, 1'b0, "R7 main off");
    host_pulse();
    chk(men, 1'b0, "R7 host cannot restart");
    chk(seen[3], 1'b1, "R7 event seen");
    pin_cycle();
    chk(fsd, 1'b0, "R7 cleared by pin cycle");
    chk(men, 1'b1, "R7 main back on");
    // R8 supply undervoltage deglitch
    seen = 0; suv = 1; tick(100); suv = 0; tick(2200);
    chk(men, 1'b1, "R8 short glitch ignored");
    chk(seen[4], 1'b0, "R8 no event on glitch");
    suv = 1; tick(2100);
    chk(men, 1'b0, "R8 long undervoltage accepted");
    chk(seen[4], 1'b1, "R8 event seen");
    suv = 0; tick(2100);
    chk(men, 1'b0, "R8 stays off until pin cycle");
    pin_cycle();
    chk(men, 1'b1, "R8 pin cycle restores");
    // R9 low battery, clamped and zero delay
    seen = 0; bdly = 7'd120; blo = 1; tick(500); blo = 0; tick(1200);
    chk(seen[5], 1'b0, "R9 short low-battery ignored");
    blo = 1; tick(1100);
    chk(seen[5], 1'b1, "R9 accepted after clamped window");
    chk(men, 1'b1, "R9 enables unaffected");
    blo = 0; tick(1100);
    seen = 0; bdly = 7'd0; blo = 1; tick(3); blo = 0; tick(3);
    chk(seen[5], 1'b1, "R9 zero delay accepted");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule